// File: doc/BRIEF.md
# I2C SCL Bit-Rate Timer

This block paces the clock line of an I2C master. A fast input clock is first slowed by an integer pre-divider to an internal tick. A bit-period counter running on that tick then splits each SCL period into a low phase and a high phase. Two one-cycle strobes mark where the master may change SDA (a quarter period in, during low) and where it should sample SDA (a quarter period later, during high). The master's sequencer raises `run_i` while it owns the bus and drives the SCL pad from `scl_low_o`.

One configuration word holds the pre-divider field and the gap field. A separate input gives the rise/fall compensation count. Software computes all three values from the target bit rate. A new word is staged on a write. It takes effect only while `run_i` is low, so a burst never sees a mid-flight change of rate. The sensed SCL line feeds back in. While a slave holds SCL low, the high phase does not advance.

Top module: `scl_rate_gen`

## Requirements
- R1: The internal tick period is 1 + DIV input clocks, where DIV is bits [2:0] of the configuration word.
- R2: One SCL period is 20 + 8·GAP + COMP internal ticks, where GAP is bits [8:3] of the configuration word (0 to 63) and COMP is the 6-bit compensation input.
- R3: The low phase lasts ceil(P/2) ticks and the high phase lasts the remaining P − ceil(P/2) ticks, where P is the period from R2.
- R4: A rising `run_i` starts a low phase at once. While `run_i` is low, both phase outputs and both strobes are 0.
- R5: `sda_chg_o` pulses exactly once per low phase. The pulse falls (L>>1)·(1+DIV) + DIV input clocks after the first low cycle, where L is the low-phase length in ticks.
- R6: `sda_smp_o` pulses exactly once per high phase. The pulse falls (H>>1)·(1+DIV) + DIV non-stalled input clocks after the first high cycle, where H is the high-phase length in ticks.
- R7: During the high phase, every input clock in which `scl_in_i` reads 0 freezes both the pre-divider and the bit counter. Each such clock lengthens the high phase by exactly one input clock.
- R8: A configuration write, and any change of the compensation input, is applied only while `run_i` is low. A change made during a burst first shows in the next burst.
- R9: After reset all outputs are 0, and the active configuration is all zeros (DIV 0, GAP 0).
- R10: `scl_low_o` and `scl_high_o` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_wr_i | input | 1 | Stage `cfg_data_i` as the pending configuration |
| cfg_data_i | input | 9 | Configuration word: GAP in [8:3], DIV in [2:0] |
| comp_f_i | input | 6 | Rise/fall compensation count in ticks |
| run_i | input | 1 | Bus owned; high to generate SCL phases |
| scl_in_i | input | 1 | Sensed level of the SCL line |
| scl_low_o | output | 1 | SCL low phase (master drives SCL low) |
| scl_high_o | output | 1 | SCL high phase (SCL released) |
| sda_chg_o | output | 1 | One-cycle strobe: SDA may change |
| sda_smp_o | output | 1 | One-cycle strobe: sample SDA |

## Verification
The checker watches several rules on every cycle. The two phase outputs must never be high together. A burst must open in the low phase. Each strobe may appear only inside its own phase, and the sample strobe only while the line reads high. A stretched high phase must hold. The active configuration must stay frozen for the whole of a burst. Exact phase lengths, strobe offsets, the pre-divider ratio and the deferral of a configuration written mid-burst all depend on multi-cycle counts. Only the bench's scoreboard, measuring each whole phase against the R2/R3 arithmetic, can show these.

// File: rtl/scl_rate_gen.sv
`timescale 1ns/1ps
module scl_rate_gen #(
  parameter int DIV_W  = 3,
  parameter int GAP_W  = 6,
  parameter int COMP_W = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cfg_wr_i,
  input  logic [DIV_W+GAP_W-1:0]   cfg_data_i,
  input  logic [COMP_W-1:0]        comp_f_i,
  input  logic                     run_i,
  input  logic                     scl_in_i,
  output logic                     scl_low_o,
  output logic                     scl_high_o,
  output logic                     sda_chg_o,
  output logic                     sda_smp_o
);
  localparam int CFG_W = DIV_W + GAP_W;
  localparam int PW    = GAP_W + 5;

  logic [CFG_W-1:0]  cfg_pend, cfg_act;
  logic [COMP_W-1:0] f_act;
  logic [DIV_W-1:0]  pre;
  logic [PW-1:0]     cnt;
  logic              hi;

  wire [DIV_W-1:0] div    = cfg_act[DIV_W-1:0];
  wire [GAP_W-1:0] gap    = cfg_act[CFG_W-1:DIV_W];
  wire [PW-1:0]    period = PW'(20) + (PW'(gap) << 3) + PW'(f_act);
  wire [PW-1:0]    len_lo = (period + PW'(1)) >> 1;
  wire [PW-1:0]    len_hi = period - len_lo;

  wire stall = hi & ~scl_in_i;
  wire tick  = run_i & ~stall & (pre == div);
  wire last  = hi ? (cnt == len_hi - PW'(1)) : (cnt == len_lo - PW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_pend <= '0;
      cfg_act  <= '0;
      f_act    <= '0;
      pre      <= '0;
      cnt      <= '0;
      hi       <= 1'b0;
    end else begin
      if (cfg_wr_i) cfg_pend <= cfg_data_i;
      if (!run_i) begin
        cfg_act <= cfg_pend;
        f_act   <= comp_f_i;
        pre     <= '0;
        cnt     <= '0;
        hi      <= 1'b0;
      end else if (!stall) begin
        pre <= (pre == div) ? '0 : pre + DIV_W'(1);
        if (tick) begin
          if (last) begin
            cnt <= '0;
            hi  <= ~hi;
          end else begin
            cnt <= cnt + PW'(1);
          end
        end
      end
    end
  end

  assign scl_low_o  = run_i & ~hi;
  assign scl_high_o = run_i & hi;
  assign sda_chg_o  = tick & ~hi & (cnt == (len_lo >> 1));
  assign sda_smp_o  = tick & hi & (cnt == (len_hi >> 1));
endmodule

module scl_rate_gen_chk #(
  parameter int CFG_W  = 9,
  parameter int COMP_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run_i,
  input logic              scl_in_i,
  input logic              scl_low_o,
  input logic              scl_high_o,
  input logic              sda_chg_o,
  input logic              sda_smp_o,
  input logic [CFG_W-1:0]  cfg_act,
  input logic [COMP_W-1:0] f_act
);
  p_phase_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(scl_low_o && scl_high_o));

  p_start_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> scl_low_o);

  p_idle_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !(scl_high_o || sda_chg_o || sda_smp_o));

  p_chg_in_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_chg_o |-> scl_low_o);

  p_smp_in_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_smp_o |-> (scl_high_o && scl_in_i));

  p_stretch_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && scl_high_o && !scl_in_i) |=> (scl_high_o || !run_i));

  p_cfg_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i)) |-> ($stable(cfg_act) && $stable(f_act)));
endmodule

bind scl_rate_gen scl_rate_gen_chk #(.CFG_W(CFG_W), .COMP_W(COMP_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .scl_in_i(scl_in_i),
  .scl_low_o(scl_low_o), .scl_high_o(scl_high_o),
  .sda_chg_o(sda_chg_o), .sda_smp_o(sda_smp_o),
  .cfg_act(cfg_act), .f_act(f_act));

// File: tb/scl_rate_gen_tb_top.sv
`timescale 1ns/1ps
module scl_rate_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [8:0] cfg_data = '0;
  logic [5:0] comp_f = '0;
  logic       run = 1'b0;
  logic       ext_hold = 1'b0;
  logic       scl_in, scl_low, scl_high, sda_chg, sda_smp;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  assign scl_in = ~scl_low & ~ext_hold;

  always #(CLK_PERIOD/2) clk = ~clk;

  scl_rate_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .cfg_data_i(cfg_data),
    .comp_f_i(comp_f), .run_i(run), .scl_in_i(scl_in),
    .scl_low_o(scl_low), .scl_high_o(scl_high),
    .sda_chg_o(sda_chg), .sda_smp_o(sda_smp));

  typedef struct { int kind; int len; int stb; string req; } exp_t;
  exp_t exp_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr_cfg(input int div, input int gap);
    cfg_data = 9'((gap << 3) | div);
    cfg_wr = 1'b1;
    step();
    cfg_wr = 1'b0;
  endtask

  task automatic push_burst(input int div, input int gap, input int f, input int nbits, input string req);
    int d = div + 1;
    int p = 20 + 8 * gap + f;
    int l = (p + 1) / 2;
    int h = p - l;
    for (int i = 0; i < nbits; i++) begin
      exp_q.push_back('{1, l * d, (l >> 1) * d + div, req});
      exp_q.push_back('{2, h * d, (h >> 1) * d + div, req});
    end
  endtask

  task automatic finish_burst(input string req);
    while (exp_q.size() > 0) step();
    run = 1'b0;
    step();
    check(!scl_low && !scl_high && !sda_chg && !sda_smp, {req, " R4 idle outputs"},
          int'({scl_low, scl_high, sda_chg, sda_smp}), 0);
    step();
  endtask

  int ph = 0, n = 0, stalls = 0, stb_cnt = 0, stb_at = -1, stb_stalls = 0;

  always @(negedge clk) begin
    int cur;
    exp_t e;
    if (!rst_n) begin
      ph = 0; n = 0;
    end else begin
      cur = scl_low ? 1 : (scl_high ? 2 : 0);
      if (cur != ph) begin
        if (ph != 0 && cur != 0) begin
          if (exp_q.size() == 0) begin
            check(0, "R4 unexpected phase", ph, 0);
          end else begin
            e = exp_q.pop_front();
            check(ph == e.kind, {e.req, " R3 phase order"}, ph, e.kind);
            check(n == e.len + stalls, {e.req, " R1 R2 R3 R7 phase length"}, n, e.len + stalls);
            check(stb_cnt == 1 && stb_at == e.stb + stb_stalls,
                  {e.req, (ph == 1) ? " R5 change strobe" : " R6 sample strobe"},
                  stb_at, e.stb + stb_stalls);
          end
        end
        n = 0; stalls = 0; stb_cnt = 0; stb_at = -1; stb_stalls = 0;
      end
      ph = cur;
      if (cur != 0) begin
        if ((cur == 1 && sda_chg) || (cur == 2 && sda_smp)) begin
          stb_cnt++; stb_at = n; stb_stalls = stalls;
        end
        if (cur == 2 && !scl_in) stalls++;
        n++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    check(!scl_low && !scl_high && !sda_chg && !sda_smp, "R9 reset outputs",
          int'({scl_low, scl_high, sda_chg, sda_smp}), 0);
    rst_n = 1'b1;
    step(); step();

    // R9: reset configuration gives DIV 0, GAP 0
    push_burst(0, 0, 0, 2, "R9 reset cfg");
    run = 1'b1;
    finish_burst("R9");

    // R1 R2: divided tick, mid gap
    wr_cfg(3, 2); comp_f = 6'd7; step(); step(); step();
    push_burst(3, 2, 7, 2, "R1 R2 div4");
    run = 1'b1;
    finish_burst("R1");

    // R3: odd period
    wr_cfg(1, 1); comp_f = 6'd1; step(); step(); step();
    push_burst(1, 1, 1, 3, "R3 odd period");
    run = 1'b1;
    finish_burst("R3");

    // R2: maximum fields
    wr_cfg(7, 63); comp_f = 6'd63; step(); step(); step();
    push_burst(7, 63, 63, 1, "R2 max fields");
    run = 1'b1;
    finish_burst("R2");

    // R8: write during burst is deferred
    wr_cfg(2, 0); comp_f = 6'd2; step(); step(); step();
    push_burst(2, 0, 2, 3, "R8 old cfg kept");
    run = 1'b1;
    repeat (5) step();
    wr_cfg(0, 4); comp_f = 6'd9;
    finish_burst("R8");
    push_burst(0, 4, 9, 2, "R8 new cfg applied");
    run = 1'b1;
    finish_burst("R8");

    // R7: slave stretches the first high phase
    wr_cfg(3, 2); comp_f = 6'd7; step(); step(); step();
    push_burst(3, 2, 7, 2, "R7 stretch");
    ext_hold = 1'b1;
    run = 1'b1;
    while (!scl_high) step();
    repeat (6) step();
    ext_hold = 1'b0;
    finish_burst("R7");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule